// File: doc/BRIEF.md
# UART Software Flow Controller

This block adds in-band XON/XOFF flow control to a byte-wide UART datapath. It sits between the deserializer and the receive FIFO. It watches every received byte for the two programmable control characters. A received XOFF pauses the local transmitter and a received XON resumes it. Either character can optionally be removed from the stream before it is written to the FIFO.

In the other direction, the block compares the receive FIFO fill level against two programmable thresholds. When the FIFO runs high, it asks the transmitter to insert an XOFF character. Once the FIFO has drained, it asks for an XON. Each request is held until the transmitter acknowledges it. A request that is still pending is replaced by a newer one.

Software can force the transmitter into the paused state with a level control. It can also release a paused transmitter with a one-cycle force-resume strobe. A global enable switches the whole mechanism off. While it is off, every byte passes through untouched and no character is requested.

Top module: `swfc_top`

## Requirements
- R1: After reset, txPause, insReq, outValid, irqXonRx and irqXoffRx are all 0.
- R2: A received byte that is not a detected control character appears on outByte, with outValid high for one cycle, in the cycle after rxValid.
- R3: With cfgEnable=1, a received byte equal to cfgXoffChar sets txPause from the next cycle. It also raises irqXoffRx for exactly that one cycle. If cfgXonChar equals cfgXoffChar, the byte counts as XOFF.
- R4: With cfgEnable=1, a received byte equal to cfgXonChar clears the paused state from the next cycle and raises irqXonRx for exactly that one cycle.
- R5: With cfgEnable=1 and cfgStrip=1, a detected control character is not forwarded (outValid stays 0). With cfgStrip=0 it is forwarded like any other byte.
- R6: With cfgEnable=0, control characters are forwarded, raise no interrupt, change no pause state and produce no insertion request. Dropping cfgEnable clears the paused state and any pending request at the next edge.
- R7: When fifoLevel becomes greater than or equal to cfgXoffLevel, insReq rises in the next cycle with insChar equal to cfgXoffChar. Only one request is made per crossing: no further XOFF request is made until an XON has been requested.
- R8: After an XOFF request, fifoLevel falling to less than or equal to cfgXonLevel raises insReq in the next cycle with insChar equal to cfgXonChar.
- R9: insReq stays high until insAck is sampled high at a clock edge, and is low after that edge unless a new request arises at the same edge.
- R10: If a new XON or XOFF request arises while one is pending, insChar switches to the newer character and insReq stays high.
- R11: While cfgForceXoff is 1, txPause is 1 in the same cycle regardless of cfgEnable. Threshold-driven insertion requests are still issued.
- R12: A one-cycle pulse on cfgForceXon clears the paused state set by a received XOFF. With cfgForceXoff low, txPause is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Global enable for software flow control |
| cfgStrip | input | 1 | Remove detected control characters from the stream |
| cfgXonChar | input | 8 | Resume character value |
| cfgXoffChar | input | 8 | Pause character value |
| cfgXonLevel | input | LEVEL_W | FIFO level at or below which XON is requested |
| cfgXoffLevel | input | LEVEL_W | FIFO level at or above which XOFF is requested |
| cfgForceXoff | input | 1 | Hold the transmitter paused while set |
| cfgForceXon | input | 1 | One-cycle strobe that clears the paused state |
| rxByte | input | 8 | Byte from the deserializer |
| rxValid | input | 1 | rxByte is valid this cycle |
| fifoLevel | input | LEVEL_W | Current receive FIFO fill level |
| outByte | output | 8 | Byte towards the receive FIFO |
| outValid | output | 1 | Write strobe for outByte |
| txPause | output | 1 | Gate for the local transmitter |
| insReq | output | 1 | Request to insert a flow control character |
| insChar | output | 8 | Character to insert |
| insAck | input | 1 | Transmitter has taken the inserted character |
| irqXonRx | output | 1 | Pulse: XON received |
| irqXoffRx | output | 1 | Pulse: XOFF received |

## Verification
Every registered result is due exactly one clock edge after the stimulus that causes it. This applies to the forwarded byte, the interrupt pulses, the pause state after a received character or a force-resume, and the insertion request after a threshold crossing or an acknowledge. The only same-cycle result is txPause following cfgForceXoff. The bench drives its inputs one time unit after a rising edge, then advances exactly one edge and samples one time unit later. Each result is therefore read in the first cycle it is due, and never in the cycle before. The hold checks on insReq and txPause step several edges without stimulus, so that a result that decays too early is also caught.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  // Strobes from the datapath to the control logic
  typedef struct packed {
    logic xonSeen;
    logic xoffSeen;
    logic overHigh;
    logic underLow;
  } swfcEvt_t;
endpackage

// File: rtl/swfc_datapath.sv
module swfc_datapath
  import swfc_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int CHAR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgStrip,
  input  logic [CHAR_W-1:0]  cfgXonChar,
  input  logic [CHAR_W-1:0]  cfgXoffChar,
  input  logic [LEVEL_W-1:0] cfgXonLevel,
  input  logic [LEVEL_W-1:0] cfgXoffLevel,
  input  logic [CHAR_W-1:0]  rxByte,
  input  logic               rxValid,
  input  logic [LEVEL_W-1:0] fifoLevel,
  output swfcEvt_t           evt,
  output logic [CHAR_W-1:0]  outByte,
  output logic               outValid,
  output logic               irqXonRx,
  output logic               irqXoffRx
);
  logic xoffHit;
  logic xonHit;
  logic dropByte;

  // XOFF wins when both characters are programmed to the same value
  assign xoffHit  = cfgEnable && rxValid && (rxByte == cfgXoffChar);
  assign xonHit   = cfgEnable && rxValid && (rxByte == cfgXonChar) && !xoffHit;
  assign dropByte = cfgStrip && (xoffHit || xonHit);

  always_comb begin
    evt.xonSeen  = xonHit;
    evt.xoffSeen = xoffHit;
    evt.overHigh = fifoLevel >= cfgXoffLevel;
    evt.underLow = fifoLevel <= cfgXonLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outByte   <= '0;
      outValid  <= 1'b0;
      irqXonRx  <= 1'b0;
      irqXoffRx <= 1'b0;
    end else begin
      outValid  <= rxValid && !dropByte;
      irqXonRx  <= xonHit;
      irqXoffRx <= xoffHit;
      if (rxValid) outByte <= rxByte;
    end
  end

  // R5
  strip_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && cfgEnable && cfgStrip && (rxByte == cfgXoffChar)) |=> !outValid);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !cfgEnable) |=> (outValid && outByte == $past(rxByte)));

  // R3
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqXonRx, irqXoffRx}));
endmodule

// File: rtl/swfc_control.sv
module swfc_control
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgForceXoff,
  input  logic              cfgForceXon,
  input  logic [CHAR_W-1:0] cfgXonChar,
  input  logic [CHAR_W-1:0] cfgXoffChar,
  input  swfcEvt_t          evt,
  input  logic              insAck,
  output logic              txPause,
  output logic              insReq,
  output logic [CHAR_W-1:0] insChar
);
  logic pausedQ;
  logic throttledQ;
  logic reqValidQ;
  logic reqIsXoffQ;
  logic raiseXoff;
  logic raiseXon;

  assign raiseXoff = cfgEnable && !throttledQ && evt.overHigh;
  assign raiseXon  = cfgEnable && throttledQ && evt.underLow;

  // Remote pause state from in-band characters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pausedQ <= 1'b0;
    else if (!cfgEnable)     pausedQ <= 1'b0;
    else if (cfgForceXon)    pausedQ <= 1'b0;
    else if (evt.xoffSeen)   pausedQ <= 1'b1;
    else if (evt.xonSeen)    pausedQ <= 1'b0;
  end

  // Threshold tracking and the single pending insertion slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      throttledQ <= 1'b0;
      reqValidQ  <= 1'b0;
      reqIsXoffQ <= 1'b0;
    end else if (!cfgEnable) begin
      throttledQ <= 1'b0;
      reqValidQ  <= 1'b0;
    end else if (raiseXoff) begin
      throttledQ <= 1'b1;
      reqValidQ  <= 1'b1;
      reqIsXoffQ <= 1'b1;
    end else if (raiseXon) begin
      throttledQ <= 1'b0;
      reqValidQ  <= 1'b1;
      reqIsXoffQ <= 1'b0;
    end else if (reqValidQ && insAck) begin
      reqValidQ  <= 1'b0;
    end
  end

  assign txPause = pausedQ || cfgForceXoff;
  assign insReq  = reqValidQ;
  assign insChar = reqIsXoffQ ? cfgXoffChar : cfgXonChar;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insReq && !insAck && cfgEnable) |=> insReq);

  // R6
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!insReq && !pausedQ));

  // R3
  xoff_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.xoffSeen && !cfgForceXon) |=> txPause);

  // R12
  force_xon_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgForceXon |=> !pausedQ);
endmodule

// File: rtl/swfc_top.sv
module swfc_top
  import swfc_pkg::*;
#(
  parameter int LEVEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgStrip,
  input  logic [7:0]         cfgXonChar,
  input  logic [7:0]         cfgXoffChar,
  input  logic [LEVEL_W-1:0] cfgXonLevel,
  input  logic [LEVEL_W-1:0] cfgXoffLevel,
  input  logic               cfgForceXoff,
  input  logic               cfgForceXon,
  input  logic [7:0]         rxByte,
  input  logic               rxValid,
  input  logic [LEVEL_W-1:0] fifoLevel,
  output logic [7:0]         outByte,
  output logic               outValid,
  output logic               txPause,
  output logic               insReq,
  output logic [7:0]         insChar,
  input  logic               insAck,
  output logic               irqXonRx,
  output logic               irqXoffRx
);
  localparam int CHAR_W = 8;

  swfcEvt_t evt;

  swfc_datapath #(.LEVEL_W(LEVEL_W), .CHAR_W(CHAR_W)) datapath_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgStrip(cfgStrip),
    .cfgXonChar(cfgXonChar), .cfgXoffChar(cfgXoffChar),
    .cfgXonLevel(cfgXonLevel), .cfgXoffLevel(cfgXoffLevel),
    .rxByte(rxByte), .rxValid(rxValid), .fifoLevel(fifoLevel),
    .evt(evt), .outByte(outByte), .outValid(outValid),
    .irqXonRx(irqXonRx), .irqXoffRx(irqXoffRx)
  );

  swfc_control #(.CHAR_W(CHAR_W)) control_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable),
    .cfgForceXoff(cfgForceXoff), .cfgForceXon(cfgForceXon),
    .cfgXonChar(cfgXonChar), .cfgXoffChar(cfgXoffChar),
    .evt(evt), .insAck(insAck),
    .txPause(txPause), .insReq(insReq), .insChar(insChar)
  );

  // R11
  force_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgForceXoff |-> txPause);
endmodule

// File: tb/swfc_top_tb_top.sv
module swfc_top_tb_top;
  localparam int LW = 8;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable, cfgStrip, cfgForceXoff, cfgForceXon;
  logic [7:0] cfgXonChar, cfgXoffChar, rxByte, outByte, insChar;
  logic [LW-1:0] cfgXonLevel, cfgXoffLevel, fifoLevel;
  logic rxValid, outValid, txPause, insReq, insAck, irqXonRx, irqXoffRx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  swfc_top #(.LEVEL_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgStrip(cfgStrip),
    .cfgXonChar(cfgXonChar), .cfgXoffChar(cfgXoffChar),
    .cfgXonLevel(cfgXonLevel), .cfgXoffLevel(cfgXoffLevel),
    .cfgForceXoff(cfgForceXoff), .cfgForceXon(cfgForceXon),
    .rxByte(rxByte), .rxValid(rxValid), .fifoLevel(fifoLevel),
    .outByte(outByte), .outValid(outValid), .txPause(txPause),
    .insReq(insReq), .insChar(insChar), .insAck(insAck),
    .irqXonRx(irqXonRx), .irqXoffRx(irqXoffRx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tReset(input logic en);
    rstN = 1'b0;
    cfgEnable = en; cfgStrip = 1'b0; cfgForceXoff = 1'b0; cfgForceXon = 1'b0;
    cfgXonChar = XON; cfgXoffChar = XOFF; cfgXonLevel = 4; cfgXoffLevel = 12;
    rxByte = '0; rxValid = 1'b0; fifoLevel = '0; insAck = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxByte = b; rxValid = 1'b1;
    step();
    rxValid = 1'b0;
  endtask

  task automatic tResetState();
    tReset(1'b0);
    chk("R1 txPause", txPause, 0);
    chk("R1 insReq", insReq, 0);
    chk("R1 outValid", outValid, 0);
    chk("R1 irqs", {irqXonRx, irqXoffRx}, 0);
  endtask

  task automatic tPassThrough();
    tReset(1'b1);
    sendByte(8'hA5);
    chk("R2 valid", outValid, 1);
    chk("R2 byte", outByte, 8'hA5);
    sendByte(8'h00);
    chk("R2 byte2", outByte, 8'h00);
    step();
    chk("R2 one-cycle", outValid, 0);
  endtask

  task automatic tRxControl();
    tReset(1'b1);
    sendByte(XOFF);
    chk("R3 pause", txPause, 1);
    chk("R3 irq", {irqXonRx, irqXoffRx}, 2'b01);
    step(); step();
    chk("R3 pause held", txPause, 1);
    chk("R3 irq pulse", irqXoffRx, 0);
    sendByte(XON);
    chk("R4 resume", txPause, 0);
    chk("R4 irq", {irqXonRx, irqXoffRx}, 2'b10);
    step();
    chk("R4 irq pulse", irqXonRx, 0);
    cfgXonChar = XOFF;
    sendByte(XOFF);
    chk("R3 equal chars xoff wins", {txPause, irqXonRx, irqXoffRx}, 3'b101);
  endtask

  task automatic tStrip();
    tReset(1'b1);
    cfgStrip = 1'b1;
    sendByte(XOFF);
    chk("R5 strip xoff", outValid, 0);
    sendByte(XON);
    chk("R5 strip xon", outValid, 0);
    sendByte(8'h41);
    chk("R5 data kept", {outValid, outByte}, {1'b1, 8'h41});
    cfgStrip = 1'b0;
    sendByte(XON);
    chk("R5 no strip", {outValid, outByte}, {1'b1, XON});
  endtask

  task automatic tDisable();
    tReset(1'b0);
    cfgStrip = 1'b1;
    sendByte(XOFF);
    chk("R6 forwarded", {outValid, outByte}, {1'b1, XOFF});
    chk("R6 no irq", {irqXonRx, irqXoffRx}, 0);
    chk("R6 no pause", txPause, 0);
    fifoLevel = 20;
    step();
    chk("R6 no request", insReq, 0);
    cfgEnable = 1'b1;
    step();
    chk("R6 request after enable", insReq, 1);
    sendByte(XOFF);
    chk("R6 paused while on", txPause, 1);
    cfgEnable = 1'b0;
    step();
    chk("R6 clear on disable", {txPause, insReq}, 2'b00);
  endtask

  task automatic tThreshold();
    tReset(1'b1);
    fifoLevel = 11;
    step();
    chk("R7 below", insReq, 0);
    fifoLevel = 12;
    step();
    chk("R7 xoff req", {insReq, insChar}, {1'b1, XOFF});
    step(); step();
    chk("R9 held", insReq, 1);
    insAck = 1'b1;
    step();
    insAck = 1'b0;
    chk("R9 ack clears", insReq, 0);
    fifoLevel = 20;
    step();
    chk("R7 once per crossing", insReq, 0);
    fifoLevel = 5;
    step();
    chk("R8 above xon level", insReq, 0);
    fifoLevel = 4;
    step();
    chk("R8 xon req", {insReq, insChar}, {1'b1, XON});
    insAck = 1'b1;
    step();
    insAck = 1'b0;
    chk("R9 ack clears xon", insReq, 0);
  endtask

  task automatic tPriority();
    tReset(1'b1);
    fifoLevel = 12;
    step();
    chk("R10 first xoff", {insReq, insChar}, {1'b1, XOFF});
    fifoLevel = 3;
    step();
    chk("R10 replaced by xon", {insReq, insChar}, {1'b1, XON});
    insAck = 1'b1;
    step();
    insAck = 1'b0;
    chk("R10 ack", insReq, 0);
  endtask

  task automatic tForce();
    tReset(1'b0);
    cfgForceXoff = 1'b1;
    #1;
    chk("R11 force same cycle", txPause, 1);
    cfgEnable = 1'b1;
    fifoLevel = 12;
    step();
    chk("R11 req while forced", {insReq, insChar, txPause}, {1'b1, XOFF, 1'b1});
    insAck = 1'b1;
    step();
    insAck = 1'b0;
    sendByte(XOFF);
    cfgForceXoff = 1'b0;
    step();
    chk("R12 still paused by rx", txPause, 1);
    cfgForceXon = 1'b1;
    step();
    cfgForceXon = 1'b0;
    chk("R12 resumed", txPause, 0);
    step();
    chk("R12 stays resumed", txPause, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tResetState();
    tPassThrough();
    tRxControl();
    tStrip();
    tDisable();
    tThreshold();
    tPriority();
    tForce();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule